// File: doc/BRIEF.md
# Load-Use Interlock for a Five-Stage Pipeline

This block protects an in-order five-stage pipeline from the single dependency that result forwarding cannot cover. That dependency arises when a load sits in the execute stage and the instruction right behind it, now in decode, reads the register the load is about to write. The loaded value only exists after the memory stage, so the consumer must wait one cycle. After that cycle, the forwarding path can supply the value.

The block compares the load's destination register with both source register fields of the decoding instruction. On a match it does three things:

- It drops the program-counter write enable, so the fetch stage refetches the same instruction.
- It drops the fetch/decode register write enable, so the decoding instruction is presented again.
- It switches the control bundle headed into the decode/execute register to all zeros, so a bubble enters execute.

The bubble is made only by zeroing the execute, memory and write-back control groups. The instruction word is not touched, because it has already been decoded. Register 0 is hard-wired and never written, so a load whose destination is register 0 causes no stall.

The decision is combinational from the current contents of the two pipeline registers. The hold and the bubble therefore take effect at the next clock edge. The clock and the synchronous active-low reset serve only the embedded checks.

Top module: `ld_use_interlock`

## Requirements
- R1: When the decode/execute memory-read flag is 1, its destination field is nonzero, and that field equals the decoding instruction's first source field, the stall is raised.
- R2: When the decode/execute memory-read flag is 1, its destination field is nonzero, and that field equals the decoding instruction's second source field, the stall is raised.
- R3: When the decode/execute memory-read flag is 0, no stall is raised, whatever the register fields hold.
- R4: When the decode/execute destination field is 0, no stall is raised, even if a source field is also 0.
- R5: While stalling, the program-counter write enable and the fetch/decode write enable are both 0. Otherwise both are 1.
- R6: While stalling, bubble_sel is 1 and every bit of the execute, memory and write-back control outputs is 0.
- R7: While not stalling, bubble_sel is 0 and each control output equals its corresponding control input.
- R8: The pipeline loads bit 0 of the memory control output as the next memory-read flag. Under that condition, a stall never lasts more than one cycle, and each adjacent load-use pair costs exactly one extra cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used by the embedded checks |
| rst_n | input | 1 | Synchronous active-low reset, used by the embedded checks |
| idex_mem_rd | input | 1 | Memory-read flag of the instruction in the decode/execute register |
| idex_rt | input | RW | Destination register field of the instruction in the decode/execute register |
| ifid_rs | input | RW | First source register field of the instruction in fetch/decode |
| ifid_rt | input | RW | Second source register field of the instruction in fetch/decode |
| ex_ctrl_in | input | EX_W | Decoded execute-stage control bits |
| mem_ctrl_in | input | MEM_W | Decoded memory-stage control bits (bit 0 is memory read) |
| wb_ctrl_in | input | WB_W | Decoded write-back control bits |
| pc_we | output | 1 | Program-counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| bubble_sel | output | 1 | 1 when the control bundle is being zeroed |
| ex_ctrl_out | output | EX_W | Execute control bits into decode/execute |
| mem_ctrl_out | output | MEM_W | Memory control bits into decode/execute |
| wb_ctrl_out | output | WB_W | Write-back control bits into decode/execute |

## Verification
Most checks are combinational relations between the ports and assume nothing about the inputs. The one-cycle bound of R8 is different: it holds only if the surrounding pipeline copies bit 0 of the memory control output into the next cycle's memory-read input. The property therefore names that copy as its own precondition.

The directed part of the stimulus drives arbitrary field combinations, including back-to-back matches, and they fall outside that precondition. The closed-loop part models a decode/execute register that is fed from the block's outputs, and runs a short program through it.

// File: rtl/luh_pkg.sv
// Package: shared types for the load-use interlock.
// Assumes nothing; holds the select encoding used between the submodules.
package luh_pkg;
    typedef enum logic {
        SEL_PASS   = 1'b0,
        SEL_BUBBLE = 1'b1
    } bubble_sel_e;
endpackage

// File: rtl/luh_match.sv
// luh_match: decides whether the instruction in decode reads the register
// that a load in execute is about to write.
// Assumes register index 0 is hard-wired and never needs protection.
module luh_match #(
    parameter int RW   = 5,
    parameter int NSRC = 2
) (
    input  logic                 load_valid,
    input  logic [RW-1:0]        load_dst,
    input  logic [NSRC*RW-1:0]   src_fields,
    output logic                 hit
);
    localparam logic [RW-1:0] ZERO_REG = '0;

    logic [NSRC-1:0] src_eq;

    // One equality comparator per source field of the decoding instruction.
    for (genvar g = 0; g < NSRC; g++) begin : g_src
        assign src_eq[g] = (src_fields[g*RW +: RW] == load_dst);
    end

    // Combine the per-source matches with the load and nonzero-destination qualifiers.
    always_comb begin
        hit = load_valid && (load_dst != ZERO_REG) && (|src_eq);
    end
endmodule

// File: rtl/luh_hold.sv
// luh_hold: turns a hazard hit into the front-end freeze enables and the
// bubble select. Assumes the hit is already qualified.
module luh_hold
    import luh_pkg::*;
(
    input  logic        hazard,
    output logic        pc_en,
    output logic        fd_en,
    output bubble_sel_e sel
);
    // Freeze fetch and decode while a bubble is requested; free-run otherwise.
    always_comb begin
        if (hazard) begin
            pc_en = 1'b0;
            fd_en = 1'b0;
            sel   = SEL_BUBBLE;
        end else begin
            pc_en = 1'b1;
            fd_en = 1'b1;
            sel   = SEL_PASS;
        end
    end
endmodule

// File: rtl/luh_bubble_mux.sv
// luh_bubble_mux: passes or zeroes each control group headed into the
// decode/execute register. The instruction word is never touched here.
module luh_bubble_mux
    import luh_pkg::*;
#(
    parameter int EX_W  = 4,
    parameter int MEM_W = 3,
    parameter int WB_W  = 2
) (
    input  bubble_sel_e       sel,
    input  logic [EX_W-1:0]   ex_in,
    input  logic [MEM_W-1:0]  mem_in,
    input  logic [WB_W-1:0]   wb_in,
    output logic [EX_W-1:0]   ex_out,
    output logic [MEM_W-1:0]  mem_out,
    output logic [WB_W-1:0]   wb_out
);
    localparam int NGRP  = 3;
    localparam int TOT_W = EX_W + MEM_W + WB_W;

    logic [TOT_W-1:0] bundle_in;
    logic [TOT_W-1:0] bundle_out;

    assign bundle_in = {wb_in, mem_in, ex_in};

    // Per-group gating so that each stage group is forced low independently.
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam int LO = (g == 0) ? 0 : (g == 1) ? EX_W : EX_W + MEM_W;
        localparam int W  = (g == 0) ? EX_W : (g == 1) ? MEM_W : WB_W;
        assign bundle_out[LO +: W] = (sel == SEL_BUBBLE) ? '0 : bundle_in[LO +: W];
    end

    assign ex_out  = bundle_out[EX_W-1:0];
    assign mem_out = bundle_out[EX_W +: MEM_W];
    assign wb_out  = bundle_out[EX_W+MEM_W +: WB_W];
endmodule

// File: rtl/ld_use_interlock.sv
// ld_use_interlock: top of the load-use interlock. Compares the load in
// execute with both decode sources, freezes PC and fetch/decode for one
// cycle on a match, and zeroes the control groups entering execute.
// Assumes the pipeline writes PC and all pipeline registers every cycle
// except when these enables say otherwise. clk/rst_n feed the checks only.
module ld_use_interlock
    import luh_pkg::*;
#(
    parameter int RW        = 5,
    parameter int EX_W      = 4,
    parameter int MEM_W     = 3,
    parameter int WB_W      = 2,
    parameter int MEMRD_BIT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idex_mem_rd,
    input  logic [RW-1:0]     idex_rt,
    input  logic [RW-1:0]     ifid_rs,
    input  logic [RW-1:0]     ifid_rt,
    input  logic [EX_W-1:0]   ex_ctrl_in,
    input  logic [MEM_W-1:0]  mem_ctrl_in,
    input  logic [WB_W-1:0]   wb_ctrl_in,
    output logic              pc_we,
    output logic              ifid_we,
    output logic              bubble_sel,
    output logic [EX_W-1:0]   ex_ctrl_out,
    output logic [MEM_W-1:0]  mem_ctrl_out,
    output logic [WB_W-1:0]   wb_ctrl_out
);
    localparam int NSRC = 2;

    logic        hazard;
    bubble_sel_e sel;

    luh_match #(.RW(RW), .NSRC(NSRC)) u_match (
        .load_valid (idex_mem_rd),
        .load_dst   (idex_rt),
        .src_fields ({ifid_rt, ifid_rs}),
        .hit        (hazard)
    );

    luh_hold u_hold (
        .hazard (hazard),
        .pc_en  (pc_we),
        .fd_en  (ifid_we),
        .sel    (sel)
    );

    luh_bubble_mux #(.EX_W(EX_W), .MEM_W(MEM_W), .WB_W(WB_W)) u_mux (
        .sel     (sel),
        .ex_in   (ex_ctrl_in),
        .mem_in  (mem_ctrl_in),
        .wb_in   (wb_ctrl_in),
        .ex_out  (ex_ctrl_out),
        .mem_out (mem_ctrl_out),
        .wb_out  (wb_ctrl_out)
    );

    assign bubble_sel = (sel == SEL_BUBBLE);

    // R1: a qualified load matching the first source must freeze the front end.
    a_r1_rs_match_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (idex_mem_rd && (idex_rt != '0) && (idex_rt == ifid_rs)) |-> (!pc_we && bubble_sel));

    // R2: a qualified load matching the second source must freeze the front end.
    a_r2_rt_match_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (idex_mem_rd && (idex_rt != '0) && (idex_rt == ifid_rt)) |-> (!ifid_we && bubble_sel));

    // R3: a non-load in execute never freezes anything.
    a_r3_no_load_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        !idex_mem_rd |-> (pc_we && ifid_we));

    // R4: a load to register 0 never freezes anything.
    a_r4_zero_dst_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (idex_rt == '0) |-> !bubble_sel);

    // R5: both freeze enables move together with the bubble.
    a_r5_enables_agree: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_we == ifid_we) && (pc_we == !bubble_sel));

    // R6: a bubble carries no control bits into execute.
    a_r6_bubble_all_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bubble_sel |-> ((ex_ctrl_out == '0) && (mem_ctrl_out == '0) && (wb_ctrl_out == '0)));

    // R7: without a bubble the control bundle passes unchanged.
    a_r7_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        !bubble_sel |-> ((ex_ctrl_out == ex_ctrl_in) && (mem_ctrl_out == mem_ctrl_in)
                         && (wb_ctrl_out == wb_ctrl_in)));

    // R8: when the memory-read flag is fed back, a stall never repeats.
    a_r8_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bubble_sel) && (idex_mem_rd == $past(mem_ctrl_out[MEMRD_BIT]))) |-> !bubble_sel);
endmodule

// File: tb/ld_use_interlock_tb.sv
module ld_use_interlock_tb;
    localparam int RW = 5, EX_W = 4, MEM_W = 3, WB_W = 2;
    localparam int NPROG = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic idex_mem_rd = 1'b0;
    logic [RW-1:0] idex_rt = '0, ifid_rs = '0, ifid_rt = '0;
    logic [EX_W-1:0] ex_ctrl_in = '0;
    logic [MEM_W-1:0] mem_ctrl_in = '0;
    logic [WB_W-1:0] wb_ctrl_in = '0;
    logic pc_we, ifid_we, bubble_sel;
    logic [EX_W-1:0] ex_ctrl_out;
    logic [MEM_W-1:0] mem_ctrl_out;
    logic [WB_W-1:0] wb_ctrl_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ld_use_interlock #(.RW(RW), .EX_W(EX_W), .MEM_W(MEM_W), .WB_W(WB_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .idex_mem_rd(idex_mem_rd), .idex_rt(idex_rt),
        .ifid_rs(ifid_rs), .ifid_rt(ifid_rt),
        .ex_ctrl_in(ex_ctrl_in), .mem_ctrl_in(mem_ctrl_in), .wb_ctrl_in(wb_ctrl_in),
        .pc_we(pc_we), .ifid_we(ifid_we), .bubble_sel(bubble_sel),
        .ex_ctrl_out(ex_ctrl_out), .mem_ctrl_out(mem_ctrl_out), .wb_ctrl_out(wb_ctrl_out)
    );

    function automatic bit ref_stall(bit mr, int dst, int s1, int s2);
        return mr && (dst != 0) && ((dst == s1) || (dst == s2));
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one combination at the falling edge and compare all outputs.
    task automatic apply(bit mr, int dst, int s1, int s2, int ex, int mem, int wb, string req);
        bit st;
        @(negedge clk);
        idex_mem_rd = mr; idex_rt = RW'(dst); ifid_rs = RW'(s1); ifid_rt = RW'(s2);
        ex_ctrl_in = EX_W'(ex); mem_ctrl_in = MEM_W'(mem); wb_ctrl_in = WB_W'(wb);
        #1;
        st = ref_stall(mr, dst, s1, s2);
        chk({req, " stall"}, int'(bubble_sel), int'(st));
        chk("R5 pc_we", int'(pc_we), int'(!st));
        chk("R5 ifid_we", int'(ifid_we), int'(!st));
        chk(st ? "R6 ex" : "R7 ex", int'(ex_ctrl_out), st ? 0 : ex);
        chk(st ? "R6 mem" : "R7 mem", int'(mem_ctrl_out), st ? 0 : mem);
        chk(st ? "R6 wb" : "R7 wb", int'(wb_ctrl_out), st ? 0 : wb);
    endtask

    // Closed-loop run: a modelled decode/execute register fed from the outputs.
    task automatic run_program();
        bit   p_ld [NPROG];
        int   p_rs [NPROG];
        int   p_rt [NPROG];
        int   k = 0, cyc = 0, bubbles = 0, exp_bubbles = 0;
        bit   q_mr = 1'b0, prev_st = 1'b0;
        int   q_rt = 0;
        p_ld = '{1,0,0,1,0,1,0,1,1,0};
        p_rs = '{1,2,6,3,0,3,9,3,8,1};
        p_rt = '{2,5,7,0,0,4,4,8,9,9};
        for (int i = 0; i + 1 < NPROG; i++)
            if (ref_stall(p_ld[i], p_rt[i], p_rs[i+1], p_rt[i+1])) exp_bubbles++;
        while (k < NPROG && cyc < 100) begin
            bit st;
            @(negedge clk);
            idex_mem_rd = q_mr; idex_rt = RW'(q_rt);
            ifid_rs = RW'(p_rs[k]); ifid_rt = RW'(p_rt[k]);
            ex_ctrl_in = 4'b1010; mem_ctrl_in = p_ld[k] ? 3'b001 : 3'b100; wb_ctrl_in = 2'b11;
            #1;
            st = ref_stall(q_mr, q_rt, p_rs[k], p_rt[k]);
            chk("R1 loop stall", int'(bubble_sel), int'(st));
            chk("R6 loop mem", int'(mem_ctrl_out), st ? 0 : int'(mem_ctrl_in));
            if (prev_st) chk("R8 no repeat", int'(bubble_sel), 0);
            if (bubble_sel) bubbles++;
            prev_st = bubble_sel;
            q_mr = mem_ctrl_out[0];
            q_rt = p_rt[k];
            if (ifid_we) k++;
            cyc++;
        end
        chk("R8 bubble count", bubbles, exp_bubbles);
        chk("R8 cycle count", cyc, NPROG + exp_bubbles);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // Reset state: all-zero inputs give no stall and open enables.
        chk("R7 reset bubble", int'(bubble_sel), 0);
        chk("R5 reset pc_we", int'(pc_we), 1);
        @(negedge clk) rst_n = 1'b1;
        apply(1, 3, 3, 7, 9, 5, 2, "R1");
        apply(0, 0, 0, 0, 0, 0, 0, "R7");
        apply(1, 6, 1, 6, 15, 7, 3, "R2");
        apply(1, 31, 31, 31, 6, 1, 1, "R1");
        apply(1, 31, 30, 0, 6, 1, 1, "R7");
        apply(0, 4, 4, 4, 12, 3, 1, "R3");
        apply(1, 0, 0, 0, 11, 2, 3, "R4");
        apply(1, 0, 0, 5, 11, 2, 3, "R4");
        apply(1, 8, 2, 9, 3, 6, 2, "R7");
        apply(1, 17, 5, 17, 15, 7, 3, "R2");
        apply(1, 17, 5, 17, 15, 7, 3, "R6");
        run_program();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule